// File: doc/BRIEF.md
# Programmable clock output generator

This block drives a set of clock outputs for external pins. Each output takes one of four incoming clocks (a slow clock, two PLL outputs and the main clock) and divides it by a power of two from 1 to 64. Software works through a small register port in the bus clock domain. It sets an enable bit with a write-one-to-set register and clears it with a write-one-to-clear register. It writes a per-output configuration word and reads back which outputs are active and whether each one already runs with its latest configuration.

Changing the source mid-run has no glitch protection. Software should disable an output, write its new configuration, enable it again and then wait for the output's ready flag. The ready flag drops on each configuration write. It returns only after three things have happened: the write has been carried into the selected clock's domain, the enabled output has produced two divided clock edges, and that news has been carried back to the bus domain.

Top module: `progclk_gen`

Register map (word address on `bus_addr`): 0 = enable-set, 1 = enable-clear, 2 = active status (read), 3 = ready status (read), 8 + n = configuration of output n. In the enable, active and ready words, bit n belongs to output n. A configuration word holds the source select in bits [1:0] (0 slow, 1 first PLL, 2 second PLL, 3 main) and the prescaler exponent in bits [4:2]. Unused read bits and unmapped addresses read as zero.

## Requirements
- R1: After reset, every output is low, the active word reads 0, the ready word reads all ones (0b11) and both configuration words read 0.
- R2: A write to address 0 sets the active bit of each output whose data bit is 1 and leaves the other active bits unchanged. An active output toggles at its configured rate.
- R3: A write to address 1 clears the active bit of each output whose data bit is 1. A disabled output stays low once a few cycles of its source clock have passed.
- R4: The source field (config bits [1:0]) picks which input clock feeds the output. With exponent 0 the output period equals that input's period.
- R5: The exponent field (config bits [4:2]) with value p from 0 to 6 makes the output period 2^p times the selected input period.
- R6: Exponent codes 7 and above give division by 64.
- R7: A write to address 8+n stores bits [4:0] for readback and clears ready bit n on the next bus cycle.
- R8: Ready bit n rises again only after output n is enabled and has produced two divided rising edges with the new setting. While output n stays disabled, the bit stays 0.
- R9: Writing one output's configuration or enable bit changes neither the other output's configuration readback, its ready bit nor its output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| bus_wr | input | 1 | Write strobe, sampled on rising clk |
| bus_addr | input | 4 | Word address for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_clk | input | 4 | Input clocks: slow, PLL A, PLL B, main |
| clk_out | output | 2 | Programmable clock outputs |

## Verification
On every bus cycle the assertions check the bus-domain register behaviour. Set and clear writes must move exactly the addressed active bits, and no other write may change them. A configuration write must drop its own ready flag on the next cycle, and no other write may drop it. The timing of the output clocks can only be shown by the bench's scenarios. These are the period for each source and exponent, the saturation of exponent 7 and the output staying low after a disable. The same holds for the cross-domain return of the ready flag, which must come only once the output is enabled and has produced edges.

// File: rtl/progclk_pkg.sv
package progclk_pkg;
   localparam int SRC_W = 2;
   localparam int PRE_W = 3;
   localparam int CFG_W = SRC_W + PRE_W;

   localparam int ADR_EN_SET = 0;
   localparam int ADR_EN_CLR = 1;
   localparam int ADR_ACTIVE = 2;
   localparam int ADR_READY  = 3;
   localparam int ADR_CFG0   = 8;
endpackage

// File: rtl/progclk_sync.sv
module progclk_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= '0;
      end else begin
         pipe[0] <= d;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/progclk_regs.sv
module progclk_regs import progclk_pkg::*; #(
   parameter int N_OUT       = 2,
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter int TAG_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_wr,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   input  logic [N_OUT-1:0][TAG_W-1:0]  ack_in,
   output logic [N_OUT-1:0]             en_q,
   output logic [N_OUT-1:0][CFG_W-1:0]  cfg_q,
   output logic [N_OUT-1:0][TAG_W-1:0]  tag_q,
   output logic [N_OUT-1:0]             rdy_q
);
   localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(ADR_EN_SET);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(ADR_EN_CLR);
   localparam logic [ADDR_W-1:0] A_ACT = ADDR_W'(ADR_ACTIVE);
   localparam logic [ADDR_W-1:0] A_RDY = ADDR_W'(ADR_READY);

   logic [N_OUT-1:0][TAG_W-1:0] ack_s;
   logic unused_wdata;

   assign unused_wdata = ^bus_wdata[DATA_W-1:CFG_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         cfg_q <= '0;
         tag_q <= '0;
      end else if (bus_wr) begin
         if (bus_addr == A_SET) en_q <= en_q | bus_wdata[N_OUT-1:0];
         if (bus_addr == A_CLR) en_q <= en_q & ~bus_wdata[N_OUT-1:0];
         for (int n = 0; n < N_OUT; n++) begin
            if (bus_addr == ADDR_W'(ADR_CFG0 + n)) begin
               cfg_q[n] <= bus_wdata[CFG_W-1:0];
               tag_q[n] <= tag_q[n] + 1'b1;
            end
         end
      end
   end

   progclk_sync #(.W(N_OUT*TAG_W), .STAGES(SYNC_STAGES)) u_ack_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ack_in),
      .q    (ack_s)
   );

   always_comb begin
      for (int n = 0; n < N_OUT; n++) rdy_q[n] = (ack_s[n] == tag_q[n]);
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_ACT) bus_rdata[N_OUT-1:0] = en_q;
      if (bus_addr == A_RDY) bus_rdata[N_OUT-1:0] = rdy_q;
      for (int n = 0; n < N_OUT; n++) begin
         if (bus_addr == ADDR_W'(ADR_CFG0 + n)) bus_rdata[CFG_W-1:0] = cfg_q[n];
      end
   end
endmodule

// File: rtl/progclk_chan.sv
module progclk_chan #(
   parameter int N_SRC       = 4,
   parameter int SRC_W       = 2,
   parameter int PRE_W       = 3,
   parameter int MAX_EXP     = 6,
   parameter int TAG_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_clk,
   input  logic [SRC_W-1:0] cfg_src,
   input  logic [PRE_W-1:0] cfg_pre,
   input  logic             en,
   input  logic [TAG_W-1:0] tag,
   output logic [TAG_W-1:0] ack,
   output logic             clk_out
);
   localparam int IDX_W = (MAX_EXP > 1) ? $clog2(MAX_EXP) : 1;

   logic               sel_clk;
   logic               en_s;
   logic [TAG_W-1:0]   tag_s;
   logic [TAG_W-1:0]   tag_p;
   logic [PRE_W-1:0]   exp_eff;
   logic [MAX_EXP-1:0] cnt;
   logic [MAX_EXP-1:0] low_mask;
   logic [IDX_W-1:0]   div_idx;
   logic               tick;
   logic               div_bit;
   logic               edge_seen;

   assign sel_clk = src_clk[cfg_src];

   progclk_sync #(.W(1), .STAGES(SYNC_STAGES)) u_en_sync (
      .clk(sel_clk), .rst_n(rst_n), .d(en), .q(en_s)
   );
   progclk_sync #(.W(TAG_W), .STAGES(SYNC_STAGES)) u_tag_sync (
      .clk(sel_clk), .rst_n(rst_n), .d(tag), .q(tag_s)
   );

   // saturate out-of-range exponent codes at the largest division
   assign exp_eff  = (cfg_pre > PRE_W'(MAX_EXP)) ? PRE_W'(MAX_EXP) : cfg_pre;
   assign low_mask = {MAX_EXP{1'b1}} >> (PRE_W'(MAX_EXP) - exp_eff);
   assign div_idx  = IDX_W'(exp_eff - 1'b1);

   always_ff @(posedge sel_clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (!en_s) cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

   // a divided rising edge happens on the sel_clk edge where bit exp-1 goes high
   assign tick    = en_s && ((cnt & low_mask) == (low_mask >> 1));
   assign div_bit = (exp_eff == '0) ? sel_clk : cnt[div_idx];
   assign clk_out = en_s & div_bit;

   always_ff @(posedge sel_clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_p     <= '0;
         ack       <= '0;
         edge_seen <= 1'b0;
      end else begin
         tag_p <= tag_s;
         if (tag_s != tag_p) begin
            edge_seen <= 1'b0;
         end else if ((ack != tag_s) && tick) begin
            if (edge_seen) begin
               ack       <= tag_s;
               edge_seen <= 1'b0;
            end else begin
               edge_seen <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/progclk_gen.sv
module progclk_gen import progclk_pkg::*; #(
   parameter int N_OUT       = 2,
   parameter int N_SRC       = 4,
   parameter int MAX_EXP     = 6,
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter int TAG_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_SRC-1:0]  src_clk,
   output logic [N_OUT-1:0]  clk_out
);
   if (N_SRC != (1 << SRC_W)) begin : g_bad_src
      $error("N_SRC must match the source field width");
   end
   if (MAX_EXP < 1 || MAX_EXP >= (1 << PRE_W)) begin : g_bad_exp
      $error("MAX_EXP must fit the prescaler field");
   end
   if (N_OUT < 1 || N_OUT > DATA_W || ADR_CFG0 + N_OUT > (1 << ADDR_W)) begin : g_bad_out
      $error("N_OUT does not fit the register map");
   end
   if (CFG_W > DATA_W || SYNC_STAGES < 2 || TAG_W < 1) begin : g_bad_misc
      $error("invalid width or synchronizer depth");
   end

   logic [N_OUT-1:0]            en_q;
   logic [N_OUT-1:0]            rdy_q;
   logic [N_OUT-1:0][CFG_W-1:0] cfg_q;
   logic [N_OUT-1:0][TAG_W-1:0] tag_q;
   logic [N_OUT-1:0][TAG_W-1:0] ack_w;

   progclk_regs #(
      .N_OUT(N_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .TAG_W(TAG_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .ack_in   (ack_w),
      .en_q     (en_q),
      .cfg_q    (cfg_q),
      .tag_q    (tag_q),
      .rdy_q    (rdy_q)
   );

   for (genvar n = 0; n < N_OUT; n++) begin : g_chan
      progclk_chan #(
         .N_SRC(N_SRC), .SRC_W(SRC_W), .PRE_W(PRE_W), .MAX_EXP(MAX_EXP),
         .TAG_W(TAG_W), .SYNC_STAGES(SYNC_STAGES)
      ) u_chan (
         .rst_n  (rst_n),
         .src_clk(src_clk),
         .cfg_src(cfg_q[n][SRC_W-1:0]),
         .cfg_pre(cfg_q[n][CFG_W-1:SRC_W]),
         .en     (en_q[n]),
         .tag    (tag_q[n]),
         .ack    (ack_w[n]),
         .clk_out(clk_out[n])
      );
   end
endmodule

// File: rtl/progclk_chk.sv
module progclk_chk import progclk_pkg::*; #(
   parameter int N_OUT  = 2,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [N_OUT-1:0]  en_q,
   input logic [N_OUT-1:0]  rdy_q
);
   logic wr_set, wr_clr;
   assign wr_set = bus_wr && (bus_addr == ADDR_W'(ADR_EN_SET));
   assign wr_clr = bus_wr && (bus_addr == ADDR_W'(ADR_EN_CLR));

   // R2
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_set || wr_clr) |=> $stable(en_q));

   for (genvar n = 0; n < N_OUT; n++) begin : g_out
      // R2
      en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_set && bus_wdata[n]) |=> en_q[n]);
      // R3
      en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_clr && bus_wdata[n]) |=> !en_q[n]);
      // R7
      rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == ADDR_W'(ADR_CFG0 + n)) |=> !rdy_q[n]);
      // R9
      rdy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(bus_wr && bus_addr == ADDR_W'(ADR_CFG0 + n)) |=> !$fell(rdy_q[n]));
   end
endmodule

bind progclk_gen progclk_chk #(.N_OUT(N_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .en_q     (en_q),
   .rdy_q    (rdy_q)
);

// File: tb/progclk_gen_bench.sv
`timescale 1ns/1ps
module progclk_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  src_clk = '0;
   logic [1:0]  clk_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   real meas_per;

   progclk_gen u_progclk_gen (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_clk(src_clk), .clk_out(clk_out)
   );

   always #2   clk = ~clk;          // 250 MHz bus clock
   always #7   src_clk[0] = ~src_clk[0];
   always #3   src_clk[1] = ~src_clk[1];
   always #5   src_clk[2] = ~src_clk[2];
   always #4   src_clk[3] = ~src_clk[3];

   function automatic real src_period(input int s);
      case (s)
         0: return 14.0;
         1: return 6.0;
         2: return 10.0;
         default: return 8.0;
      endcase
   endfunction

   function automatic real exp_period(input int s, input int p);
      int e = (p > 6) ? 6 : p;
      return src_period(s) * real'(1 << e);
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 32'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      bus_addr = 4'(a);
      #1;
      d = int'(bus_rdata);
   endtask

   task automatic measure(input int i);
      realtime t0;
      meas_per = -1.0;
      fork
         begin
            if (i == 0) begin
               @(posedge clk_out[0]); t0 = $realtime; @(posedge clk_out[0]);
            end else begin
               @(posedge clk_out[1]); t0 = $realtime; @(posedge clk_out[1]);
            end
            meas_per = $realtime - t0;
         end
         begin
            #5000;
         end
      join_any
      disable fork;
   endtask

   task automatic check_period(input int i, input real exp, input string req);
      int a, e;
      measure(i);
      a = int'(meas_per * 1000.0);
      e = int'(exp * 1000.0);
      chk((a > e - 100) && (a < e + 100), req, a, e);
   endtask

   task automatic wait_ready(input int i, input string req);
      int d = 0;
      int k = 0;
      while (k < 6000) begin
         rd(3, d);
         if (d[i]) break;
         k++;
      end
      chk(d[i] == 1, req, d[i], 1);
   endtask

   task automatic sample_low(input int i, input string req);
      int highs = 0;
      for (int k = 0; k < 40; k++) begin
         #3.3;
         if (clk_out[i]) highs++;
      end
      chk(highs == 0, req, highs, 0);
   endtask

   // disable, reconfigure, enable, wait for ready, measure
   task automatic config_out(input int i, input int s, input int p);
      int d, other_cfg, other_act, act_after;
      int o = 1 - i;
      rd(8 + o, other_cfg);
      rd(2, other_act);
      wr(1, 1 << i);
      wr(8 + i, (p << 2) | s);
      rd(3, d);
      chk(d[i] == 0, "R7 ready dropped", d[i], 0);
      rd(8 + i, d);
      chk(d == ((p << 2) | s), "R7 config readback", d, (p << 2) | s);
      wr(0, 1 << i);
      wait_ready(i, "R8 ready returns");
      check_period(i, exp_period(s, p), (p > 6) ? "R6 period" : "R5 period");
      rd(8 + o, d);
      chk(d == other_cfg, "R9 other config", d, other_cfg);
      rd(2, act_after);
      chk(act_after[o] == other_act[o], "R9 other active", act_after[o], other_act[o]);
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int d;
      int highs;
      void'($urandom(32'h1234_5eed));

      // R1 reset state
      repeat (10) @(negedge clk);
      chk(clk_out == 2'b00, "R1 outputs in reset", clk_out, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      rd(2, d); chk(d == 0, "R1 active", d, 0);
      rd(3, d); chk(d == 3, "R1 ready", d, 3);
      rd(8, d); chk(d == 0, "R1 config0", d, 0);
      rd(9, d); chk(d == 0, "R1 config1", d, 0);
      sample_low(0, "R1 output0 low");
      sample_low(1, "R1 output1 low");

      // R2 enable output 0 with defaults; R4 default source period
      wr(0, 1);
      rd(2, d); chk(d == 1, "R2 set bit0 only", d, 1);
      repeat (10) @(negedge clk);
      check_period(0, 14.0, "R4 source0 div1");
      sample_low(1, "R2 output1 untouched");
      rd(3, d); chk(d == 3, "R2 ready unchanged", d, 3);

      // R3 disable
      wr(1, 1);
      rd(2, d); chk(d == 0, "R3 clear bit0", d, 0);
      repeat (20) @(negedge clk);
      sample_low(0, "R3 output0 low");

      // R8 ready stays low while disabled
      wr(8, (2 << 2) | 1);
      rd(3, d); chk(d[0] == 0, "R7 ready0 cleared", d[0], 0);
      chk(d[1] == 1, "R9 ready1 kept", d[1], 1);
      repeat (400) @(negedge clk);
      rd(3, d); chk(d[0] == 0, "R8 ready stays low disabled", d[0], 0);
      wr(0, 1);
      wait_ready(0, "R8 ready after enable");
      check_period(0, 24.0, "R5 src1 div4");

      // R4 each source with division 1
      for (int s = 0; s < 4; s++) begin
         config_out(1, s, 0);
         check_period(1, src_period(s), "R4 source select");
      end

      // R6 saturating codes
      config_out(0, 3, 7);
      config_out(0, 3, 6);
      config_out(1, 0, 7);

      // R9 output 0 keeps its period while output 1 is reconfigured
      config_out(0, 2, 1);
      config_out(1, 1, 3);
      check_period(0, 20.0, "R9 output0 period kept");

      // R3 disabled output goes low after a divided setting
      wr(1, 2);
      repeat (20) @(negedge clk);
      sample_low(1, "R3 output1 low");
      highs = 0;
      measure(0);
      chk(int'(meas_per * 1000.0) == 20000, "R9 output0 still runs", int'(meas_per * 1000.0), 20000);

      // constrained random reconfiguration
      for (int it = 0; it < 14; it++) begin
         int i = int'($urandom % 2);
         int s = int'($urandom % 4);
         int p = int'($urandom % 8);
         config_out(i, s, p);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule